// File: doc/BRIEF.md
# Bit-Serial Slave Configuration Loader

This block brings up a programmable target device by pushing a configuration image into it over a one-bit serial slave link. The image arrives one byte at a time on a valid/ready stream, and the last byte is flagged. A start pulse runs the whole bring-up. First the program line is pulsed and the block waits for the target to clear itself and then release its init line. Next every byte is shifted out on a divided configuration clock. The init and done pins are watched for a checksum error. Finally the block keeps clocking the target until it reports done.

Each wait on the target has its own timeout, counted in system clock cycles. A divider sets the minimum length of each half-period of the configuration clock. The outcome is left on a status code that holds until the next start. After any ending, good or bad, the pins return to their idle levels.

Top module: `sscfg_loader`

## Requirements
- R1: After reset, prog_n_o and cclk_o are high, busy_o and in_ready_o are low and status_o is 0 (no result).
- R2: A start_i pulse while idle raises busy_o and drives prog_n_o low in the next cycle. prog_n_o stays low until init_n_i is seen low. If init_n_i does not go low within TIMEOUT_CYC cycles, the run ends with status 2.
- R3: Once init_n_i is seen low, prog_n_o is released and the block waits for init_n_i to return high before it takes any data. If that does not happen within TIMEOUT_CYC cycles, the run ends with status 3.
- R4: Each byte is sent most significant bit first with exactly 8 rising edges of cclk_o. din_o takes the bit while cclk_o is low and holds it through the rising edge.
- R5: Every high phase and every low phase of cclk_o during a run lasts at least CLK_DIV system cycles.
- R6: in_ready_o is high only while the block waits for the next byte. A byte moves on a cycle where in_valid_i and in_ready_o are both high. A byte taken with in_last_i high is the final byte of the image.
- R7: Before each byte is taken, the block checks for a checksum error. If init_n_i is low while done_i is low, in_ready_o stays low, the run ends with status 4 and no further cclk_o edges are made.
- R8: After the final byte, din_o is held high and cclk_o keeps running until done_i is seen high. The run then ends with status 1.
- R9: If done_i is not seen high within TIMEOUT_CYC cycles after the final byte, the run ends with status 5.
- R10: While busy_o is low, prog_n_o and cclk_o are high and status_o holds its value. A start_i pulse while busy_o is high is ignored. A start_i pulse while idle clears status_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to begin a configuration run |
| in_data_i | input | BYTE_W | Image byte |
| in_last_i | input | 1 | Marks the final byte of the image |
| in_valid_i | input | 1 | Image byte present |
| in_ready_o | output | 1 | Block takes the byte this cycle |
| init_n_i | input | 1 | Target init line, low = asserted |
| done_i | input | 1 | Target done line, high = configured |
| prog_n_o | output | 1 | Program strobe to target, low = asserted |
| cclk_o | output | 1 | Configuration clock, target samples on rising edge |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A run is in progress |
| status_o | output | 3 | Result: 0 none, 1 ok, 2 no init, 3 init stuck, 4 checksum error, 5 no done |

## Verification
A behavioural target model collects the bits on each rising cclk_o edge and answers with init and done after set delays. Random images of one to six bytes are loaded with random idle gaps on the valid line and a random number of trailing clocks before done. Comparing the collected bytes with the sent bytes shows bit order, byte count and last-byte handling. The model's recorded minimum high and low widths of cclk_o show whether the divider holds. Directed runs in which the model never clears, never releases init, pulls init low in the middle of the image, or never raises done tell the four failure codes apart, and the timing of the first of these checks the length of the timeout window.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;
   typedef enum logic [2:0] {
      ST_NONE        = 3'd0,
      ST_OK          = 3'd1,
      ST_TMO_CLEAR   = 3'd2,
      ST_TMO_RELEASE = 3'd3,
      ST_CRC         = 3'd4,
      ST_TMO_DONE    = 3'd5
   } cfg_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PROG,
      PH_RELEASE,
      PH_FETCH,
      PH_SHIFT,
      PH_FINISH
   } cfg_phase_e;
endpackage

// File: rtl/sscfg_tick.sv
// Half-period strobe for the configuration clock.
module sscfg_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   generate
      if (DIV <= 1) begin : g_direct
         assign tick_o = en_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (!en_i)                    cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))    cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = en_i && (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/sscfg_timer.sv
// Phase timeout counter, restarted on each phase change.
module sscfg_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic expired_o
);
   localparam int unsigned TW = $clog2(LIMIT + 1);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clear_i)                 cnt_q <= '0;
      else if (cnt_q != TW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/sscfg_shift.sv
// Serialiser: MSB first, data set while clock low, free-running clock with data high.
module sscfg_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         freerun_i,
   output logic         active_o,
   output logic         byte_done_o,
   output logic         cclk_o,
   output logic         din_o
);
   localparam int unsigned NW = $clog2(W + 1);
   logic [W-1:0]  sreg_q;
   logic [NW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q      <= '0;
         left_q      <= '0;
         cclk_o      <= 1'b1;
         din_o       <= 1'b1;
         byte_done_o <= 1'b0;
      end else begin
         byte_done_o <= 1'b0;
         if (left_q == '0) begin
            if (load_i) begin
               sreg_q <= data_i;
               left_q <= NW'(W);
               cclk_o <= 1'b0;
               din_o  <= data_i[W-1];
            end else if (freerun_i) begin
               din_o <= 1'b1;
               if (tick_i) cclk_o <= ~cclk_o;
            end else begin
               cclk_o <= 1'b1;
               din_o  <= 1'b1;
            end
         end else if (tick_i) begin
            if (!cclk_o) begin
               cclk_o <= 1'b1;
            end else if (left_q == NW'(1)) begin
               left_q      <= '0;
               byte_done_o <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
               sreg_q <= sreg_q << 1;
               cclk_o <= 1'b0;
               din_o  <= sreg_q[W-2];
            end
         end
      end
   end

   assign active_o = (left_q != '0);
endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader
   import sscfg_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] in_data_i,
   input  logic              in_last_i,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic              init_n_i,
   input  logic              done_i,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              din_o,
   output logic              busy_o,
   output logic [2:0]        status_o
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_tmo
         $error("TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   cfg_phase_e  phase_q, phase_d;
   cfg_status_e status_q, status_d;
   logic        last_q;
   logic        crc_hit, load, freerun, expired, tick;
   logic        sh_active, sh_done;

   assign crc_hit    = !init_n_i && !done_i;
   assign in_ready_o = (phase_q == PH_FETCH) && !crc_hit;
   assign load       = in_ready_o && in_valid_i;
   assign freerun    = (phase_q == PH_FINISH);

   always_comb begin
      phase_d  = phase_q;
      status_d = status_q;
      unique case (phase_q)
         PH_IDLE: if (start_i) begin
            phase_d  = PH_PROG;
            status_d = ST_NONE;
         end
         PH_PROG: begin
            if (!init_n_i)    phase_d = PH_RELEASE;
            else if (expired) begin phase_d = PH_IDLE; status_d = ST_TMO_CLEAR; end
         end
         PH_RELEASE: begin
            if (init_n_i)     phase_d = PH_FETCH;
            else if (expired) begin phase_d = PH_IDLE; status_d = ST_TMO_RELEASE; end
         end
         PH_FETCH: begin
            if (crc_hit)      begin phase_d = PH_IDLE; status_d = ST_CRC; end
            else if (load)    phase_d = PH_SHIFT;
         end
         PH_SHIFT: if (sh_done) phase_d = last_q ? PH_FINISH : PH_FETCH;
         PH_FINISH: begin
            if (done_i)       begin phase_d = PH_IDLE; status_d = ST_OK; end
            else if (expired) begin phase_d = PH_IDLE; status_d = ST_TMO_DONE; end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         status_q <= ST_NONE;
         last_q   <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         status_q <= status_d;
         if (load) last_q <= in_last_i;
      end
   end

   sscfg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (phase_d != phase_q),
      .expired_o (expired)
   );

   sscfg_tick #(.DIV(CLK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (sh_active || freerun),
      .tick_o (tick)
   );

   sscfg_shift #(.W(BYTE_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .load_i      (load),
      .data_i      (in_data_i),
      .freerun_i   (freerun),
      .active_o    (sh_active),
      .byte_done_o (sh_done),
      .cclk_o      (cclk_o),
      .din_o       (din_o)
   );

   assign prog_n_o = (phase_q != PH_PROG);
   assign busy_o   = (phase_q != PH_IDLE);
   assign status_o = status_q;
endmodule

// File: rtl/sscfg_loader_chk.sv
module sscfg_loader_chk #(
   parameter int unsigned CLK_DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       in_ready_o,
   input logic       init_n_i,
   input logic       done_i,
   input logic       prog_n_o,
   input logic       cclk_o,
   input logic       din_o,
   input logic       busy_o,
   input logic [2:0] status_o
);
   logic        prev_clk_q;
   logic [15:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk_q <= 1'b1;
         hold_q     <= '0;
      end else begin
         prev_clk_q <= cclk_o;
         if (cclk_o != prev_clk_q)  hold_q <= '0;
         else if (hold_q != 16'hFFFF) hold_q <= hold_q + 1'b1;
      end
   end

   AST_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> busy_o); // R2
   AST_START_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (!prog_n_o && busy_o)); // R2
   AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> (busy_o && prog_n_o && cclk_o)); // R6
   AST_CRC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_n_i && !done_i) |-> !in_ready_o); // R7
   AST_DIN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_o) |-> $stable(din_o)); // R4
   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_clk_q && !cclk_o) |-> (32'(hold_q) >= CLK_DIV - 1)); // R5
   AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && status_o == 3'd1) |-> $past(done_i)); // R8
   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> (prog_n_o && cclk_o)); // R10
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(status_o)); // R10
endmodule

bind sscfg_loader sscfg_loader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .in_ready_o (in_ready_o),
   .init_n_i   (init_n_i),
   .done_i     (done_i),
   .prog_n_o   (prog_n_o),
   .cclk_o     (cclk_o),
   .din_o      (din_o),
   .busy_o     (busy_o),
   .status_o   (status_o)
);

// File: tb/tb_sscfg_loader.sv
`timescale 1ns/1ps
module tb_sscfg_loader;
   localparam int DIV = 3;
   localparam int TMO = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] in_data_i = '0;
   logic       in_last_i = 1'b0;
   logic       in_valid_i = 1'b0;
   logic       in_ready_o, prog_n_o, cclk_o, din_o, busy_o;
   logic [2:0] status_o;
   logic       init_q, done_q, init_n_i, done_i;

   // model knobs, written only by the stimulus process
   bit m_clear_en = 1'b1, m_release_en = 1'b1, crc_force = 1'b0;
   int exp_n = 1, done_extra = 0;

   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   assign init_n_i = init_q && !crc_force;
   assign done_i   = done_q;

   sscfg_loader #(.BYTE_W(8), .CLK_DIV(DIV), .TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_data_i(in_data_i),
      .in_last_i(in_last_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
      .init_n_i(init_n_i), .done_i(done_i), .prog_n_o(prog_n_o),
      .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o), .status_o(status_o));

   // ---------------- target model ----------------
   logic [7:0] cap [0:15];
   logic [7:0] cap_sr, sr_new;
   int cap_n, bitc, edges, prog_cnt, rel_cnt, run_len;
   int min_low, min_high, low_len, high_len, din_low_err, ready_err;
   logic cclk_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b1; done_q <= 1'b0; cap_n <= 0; bitc <= 0; edges <= 0;
         prog_cnt <= 0; rel_cnt <= 0; cclk_prev <= 1'b1; cap_sr <= '0;
         min_low <= 1000; min_high <= 1000; low_len <= 0; high_len <= 0;
         din_low_err <= 0; ready_err <= 0;
      end else begin
         cclk_prev <= cclk_o;
         if (in_ready_o && (!cclk_o || !prog_n_o || !init_n_i)) ready_err <= ready_err + 1;
         if (start_i && !busy_o) begin
            init_q <= 1'b1; done_q <= 1'b0; cap_n <= 0; bitc <= 0; edges <= 0;
            prog_cnt <= 0; rel_cnt <= 0; din_low_err <= 0;
         end else begin
            if (!prog_n_o) prog_cnt <= prog_cnt + 1; else prog_cnt <= 0;
            if (m_clear_en && prog_cnt == 4) init_q <= 1'b0;
            if (prog_n_o && !init_q) rel_cnt <= rel_cnt + 1; else rel_cnt <= 0;
            if (m_release_en && rel_cnt == 4) init_q <= 1'b1;
            if (!cclk_prev && cclk_o) begin
               edges <= edges + 1;
               if (edges < 8 * exp_n) begin
                  sr_new = {cap_sr[6:0], din_o};
                  cap_sr <= sr_new;
                  if (bitc == 7) begin cap[cap_n[3:0]] <= sr_new; cap_n <= cap_n + 1; bitc <= 0; end
                  else bitc <= bitc + 1;
               end else if (!din_o) din_low_err <= din_low_err + 1;
               if (edges + 1 >= 8 * exp_n + done_extra) done_q <= 1'b1;
            end
         end
         if (!cclk_o) low_len <= low_len + 1; else low_len <= 0;
         if (cclk_o) high_len <= high_len + 1; else high_len <= 0;
         if (!cclk_prev && cclk_o && busy_o && low_len < min_low) min_low <= low_len;
         if (cclk_prev && !cclk_o && busy_o && high_len < min_high) min_high <= high_len;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_status(input bit clr, input bit rel, input bit crc, input int extra);
      if (!clr) return 2;
      if (!rel) return 3;
      if (crc) return 4;
      if (extra > TMO / (2 * DIV)) return 5;
      return 1;
   endfunction

   logic [7:0] img [0:15];

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic feed(input int n, input int crc_at, input bit restart_at1);
      for (int i = 0; i < n; i++) begin
         if (i == crc_at) crc_force = 1'b1;
         if (restart_at1 && i == 1) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
         repeat ($urandom_range(0, 3)) @(negedge clk);
         in_data_i = img[i]; in_last_i = (i == n - 1); in_valid_i = 1'b1;
         while (!in_ready_o && busy_o) @(negedge clk);
         if (!busy_o) break;
         @(negedge clk);
      end
      in_valid_i = 1'b0; in_last_i = 1'b0;
   endtask

   task automatic wait_idle();
      run_len = 0;
      while (busy_o) begin @(negedge clk); run_len++; end
   endtask

   task automatic good_run(input int n, input int extra, input bit restart);
      int st;
      exp_n = n; done_extra = extra; m_clear_en = 1; m_release_en = 1;
      for (int i = 0; i < n; i++) img[i] = 8'($urandom);
      if (n >= 2) begin img[0] = 8'h80; img[n-1] = 8'h01; end
      pulse_start();
      chk(status_o == 3'd0 && busy_o, "R10", "status cleared on start", status_o, 0);
      feed(n, -1, restart);
      wait_idle();
      st = exp_status(1, 1, 0, extra);
      chk(status_o == 3'(st), "R8", "success status", status_o, st);
      chk(cap_n == n, "R6", "bytes delivered", cap_n, n);
      for (int i = 0; i < n; i++)
         chk(cap[i] == img[i], "R4", "byte MSB-first", cap[i], img[i]);
      chk(din_low_err == 0, "R8", "din high after data", din_low_err, 0);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(prog_n_o && cclk_o && !busy_o && !in_ready_o, "R1", "idle pins after reset",
          {prog_n_o, cclk_o, busy_o, in_ready_o}, 4'b1100);
      chk(status_o == 3'd0, "R1", "status after reset", status_o, 0);

      // directed: single byte, done right at last edge
      good_run(1, 0, 0);
      // start pulse mid-run must be ignored
      good_run(4, 2, 1);
      // random images
      for (int r = 0; r < 8; r++) good_run($urandom_range(1, 6), $urandom_range(0, 4), 0);
      chk(min_low >= DIV, "R5", "min low phase", min_low, DIV);
      chk(min_high >= DIV, "R5", "min high phase", min_high, DIV);
      chk(ready_err == 0, "R6", "ready only in byte wait", ready_err, 0);

      // init never asserted
      m_clear_en = 0;
      pulse_start();
      chk(!prog_n_o, "R2", "program asserted", prog_n_o, 0);
      wait_idle();
      chk(status_o == 3'(exp_status(0, 1, 0, 0)), "R2", "clear timeout status", status_o, 2);
      chk(run_len >= TMO - 2 && run_len <= TMO + 2, "R2", "timeout length", run_len, TMO);
      repeat (20) @(negedge clk);
      chk(status_o == 3'd2 && prog_n_o && cclk_o, "R10", "sticky status, idle pins", status_o, 2);
      m_clear_en = 1;

      // init never released
      m_release_en = 0;
      pulse_start();
      wait_idle();
      chk(status_o == 3'(exp_status(1, 0, 0, 0)), "R3", "release timeout status", status_o, 3);
      chk(cap_n == 0 && edges == 0, "R3", "no data before release", edges, 0);
      m_release_en = 1;

      // checksum error after two bytes
      exp_n = 4; done_extra = 0;
      for (int i = 0; i < 4; i++) img[i] = 8'($urandom);
      pulse_start();
      feed(4, 2, 0);
      wait_idle();
      chk(status_o == 3'(exp_status(1, 1, 1, 0)), "R7", "crc status", status_o, 4);
      chk(cap_n == 2 && edges == 16, "R7", "edges before crc stop", edges, 16);
      chk(ready_err == 0, "R7", "ready low on crc", ready_err, 0);
      crc_force = 1'b0;
      repeat (10) @(negedge clk);

      // done never rises
      exp_n = 2; done_extra = 100000;
      img[0] = 8'hA5; img[1] = 8'h3C;
      pulse_start();
      feed(2, -1, 0);
      wait_idle();
      chk(status_o == 3'(exp_status(1, 1, 0, 100000)), "R9", "done timeout status", status_o, 5);
      chk(cap[0] == 8'hA5 && cap[1] == 8'h3C, "R4", "bytes before done timeout", cap[1], 8'h3C);
      @(negedge clk); @(negedge clk);
      chk(cclk_o && prog_n_o, "R10", "clock high after abort", cclk_o, 1);
      chk(din_low_err == 0, "R8", "din high in done wait", din_low_err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog run_len=%0d expected=finish", run_len);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule